// File: doc/BRIEF.md
# SD Command Path Engine

This block is the command half of an SD/MMC host controller. A single start pulse captures a 6-bit command index, a 32-bit argument and a 2-bit response code. The block then sends a 48-bit command token on the CMD line, one bit per card clock, and listens on the same line for the card's reply. The reply is checked with CRC7, and its payload is stored in four 32-bit response words. The outcome is recorded as sticky status flags. A flag clears when a 1 is presented on the matching bit of the clear input. A mask input selects which flags drive the interrupt.

After a reply that carries a busy indication, the block can also watch data line 0. If the line is low, it waits for the line to return high, and gives up when a programmed limit of card clocks runs out. A command can be marked as a stop command. When that command's token has been fully sent, the block pulses a signal that tells the data path to abort.

The card clock is derived internally from the system clock by a fixed divider. The block drives and samples the CMD line on the falling edge of the card clock it outputs.

Top module: `sdcmd_engine`

## Requirements
- R1: The token is sent MSB first, one bit per card clock. Its layout is start bit 0, transmission bit 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, register starting at zero) of those first 40 bits, and end bit 1. `cmd_oe` is high only while the token is driven, and `cmd_out` idles at 1.
- R2: A start pulse is accepted only while `cmd_active` is low. A start pulse during an active command does not change the token being sent or the command's outcome.
- R3: Response code 00 means no response is awaited. When the token completes, status bit 3 (sent) is set and the block returns to idle.
- R4: Response code 01 awaits a 48-bit reply and checks its CRC7 over reply bits 47..8. On a match, status bit 2 (response received) is set and reply bits 39..8 go to `resp_w0`. On a mismatch, status bit 0 (CRC fail) is set and bit 2 is not.
- R5: Response code 10 awaits a 48-bit reply and ignores its CRC. Status bit 2 is set and reply bits 39..8 go to `resp_w0` whatever CRC value the reply carries.
- R6: Response code 11 awaits a 136-bit reply and checks its CRC7 over reply bits 127..8 only. Reply bits 127..0 fill `resp_w0` (most significant) through `resp_w3`. A mismatch sets status bit 0.
- R7: If no start bit (CMD low) is seen within 64 card clocks after the token ends, status bit 1 (command timeout) is set. A reply that starts 55 card clocks late is still received.
- R8: If `cmd_busy_wait` was set, the reply is valid and data line 0 is low when the reply ends, status bit 4 (busy) is set. Status bit 5 (busy end) is set once data line 0 is sampled high. If the line is already high, neither bit is set.
- R9: If data line 0 stays low for `data_timer` card clocks of busy waiting, status bit 6 (data timeout) is set and the block returns to idle.
- R10: Status bits are sticky. A 1 on a bit of `flag_clear` clears that bit in the next cycle and leaves the others unchanged. All status bits are 0 after reset.
- R11: `irq` is high, one cycle after the status changes, exactly when some status bit is set whose `flag_mask` bit is also 1.
- R12: `data_abort` pulses for one cycle when the token of a command issued with `cmd_stop` set has been fully sent. It never pulses for other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse that captures the command fields |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | Response code: 00 none, 01 short checked, 10 short unchecked, 11 long |
| cmd_busy_wait | input | 1 | Reply may signal busy on data line 0 |
| cmd_stop | input | 1 | Command aborts the data path |
| data_timer | input | DTW | Busy wait limit in card clocks |
| flag_clear | input | 7 | Clear strobe, one bit per status flag |
| flag_mask | input | 7 | Interrupt enable, one bit per status flag |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line input |
| dat0_in | input | 1 | Data line 0 input |
| status | output | 7 | Sticky status flags |
| irq | output | 1 | Masked interrupt |
| resp_w0 | output | 32 | Response word 0 (short payload or long bits 127..96) |
| resp_w1 | output | 32 | Response word 1 (long bits 95..64) |
| resp_w2 | output | 32 | Response word 2 (long bits 63..32) |
| resp_w3 | output | 32 | Response word 3 (long bits 31..0) |
| cmd_active | output | 1 | A command is in progress |
| data_abort | output | 1 | One-cycle abort pulse after a stop command |

## Verification
The bench sends replies with both good and corrupted CRC7 for each response code. A design that checked the CRC over the wrong span of a long reply, or that checked it when the code asks to ignore it, would set the wrong flag. A second start pulse is fired in the middle of a token; a design that reloaded on it would send a different index. The bench also covers a reply that never comes, a late reply that must still be accepted, busy with and without data line 0 low, and a busy wait that outlives its limit. Selective clearing, the interrupt mask and the stop pulse are checked as well, so a design that cleared every flag or pulsed abort on every command would be caught.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int NFLAG      = 7;
  localparam int TOKEN_BITS = 48;
  localparam int LONG_BITS  = 136;

  localparam int F_CRCFAIL = 0;
  localparam int F_CTMO    = 1;
  localparam int F_RESPOK  = 2;
  localparam int F_SENT    = 3;
  localparam int F_BUSY    = 4;
  localparam int F_BUSYEND = 5;
  localparam int F_DTMO    = 6;

  typedef enum logic [1:0] {
    RK_NONE        = 2'b00,
    RK_SHORT       = 2'b01,
    RK_SHORT_NOCRC = 2'b10,
    RK_LONG        = 2'b11
  } resp_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX, ST_BUSY} cmd_state_e;

  // One serial step of CRC7, polynomial x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_40(input logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic sd_clk
);
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign tick   = (cnt == CW'(DIV - 1));
  assign cnt_nx = tick ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sd_clk <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      sd_clk <= (cnt_nx >= CW'(HALF));
    end
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  load,
  input  logic [TOKEN_BITS-1:0] token,
  output logic                  cmd_out,
  output logic                  cmd_oe,
  output logic                  busy,
  output logic                  done
);
  localparam int LW = $clog2(TOKEN_BITS + 1);

  logic [TOKEN_BITS-1:0] sh;
  logic [LW-1:0]         left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      left    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh   <= token;
        left <= LW'(TOKEN_BITS);
        busy <= 1'b1;
      end else if (tick && busy) begin
        if (left != '0) begin
          cmd_out <= sh[TOKEN_BITS-1];
          cmd_oe  <= 1'b1;
          sh      <= {sh[TOKEN_BITS-2:0], 1'b0};
          left    <= left - 1'b1;
        end else begin
          cmd_out <= 1'b1;
          cmd_oe  <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  p_oe_inside_token_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy);
  p_released_at_end_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cmd_oe && cmd_out));
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 arm,
  input  logic                 long_resp,
  input  logic                 cmd_in,
  output logic                 done,
  output logic                 timeout,
  output logic                 crc_ok,
  output logic [LONG_BITS-1:0] frame
);
  localparam int WTW = $clog2(TIMEOUT + 1);

  logic                 waiting, recv, long_q;
  logic [WTW-1:0]       wcnt;
  logic [7:0]           rcnt, len, lo, hi;
  logic [6:0]           crc;
  logic [LONG_BITS-1:0] sh;
  logic                 covered;

  assign len     = long_q ? 8'(LONG_BITS) : 8'(TOKEN_BITS);
  assign lo      = long_q ? 8'd8   : 8'd0;
  assign hi      = long_q ? 8'd128 : 8'd40;
  assign covered = (rcnt >= lo) && (rcnt < hi);
  assign crc_ok  = (crc == sh[7:1]);
  assign frame   = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      recv    <= 1'b0;
      long_q  <= 1'b0;
      wcnt    <= '0;
      rcnt    <= '0;
      crc     <= '0;
      sh      <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (arm) begin
        waiting <= 1'b1;
        recv    <= 1'b0;
        wcnt    <= '0;
        rcnt    <= '0;
        crc     <= '0;
        long_q  <= long_resp;
      end else if (tick && waiting) begin
        if (!cmd_in) begin
          waiting <= 1'b0;
          recv    <= 1'b1;
          sh      <= {sh[LONG_BITS-2:0], 1'b0};
          rcnt    <= 8'd1;
          if (lo == 8'd0) crc <= crc7_step(crc, 1'b0);
        end else if (wcnt == WTW'(TIMEOUT - 1)) begin
          waiting <= 1'b0;
          timeout <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end else if (tick && recv) begin
        sh <= {sh[LONG_BITS-2:0], cmd_in};
        if (covered) crc <= crc7_step(crc, cmd_in);
        if (rcnt == len - 8'd1) begin
          recv <= 1'b0;
          done <= 1'b1;
        end
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  p_single_outcome_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout}));
  p_timeout_line_idle_r7: assert property (@(posedge clk) disable iff (rst)
    timeout |-> $past(cmd_in));
endmodule

// File: rtl/sdcmd_busywait.sv
module sdcmd_busywait #(
  parameter int DTW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           arm,
  input  logic [DTW-1:0] limit,
  input  logic           dat0,
  output logic           busy_end,
  output logic           dtimeout,
  output logic           active
);
  logic [DTW-1:0] cnt, limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      limit_q  <= '0;
      active   <= 1'b0;
      busy_end <= 1'b0;
      dtimeout <= 1'b0;
    end else begin
      busy_end <= 1'b0;
      dtimeout <= 1'b0;
      if (arm) begin
        cnt     <= '0;
        limit_q <= limit;
        active  <= 1'b1;
      end else if (tick && active) begin
        if (dat0) begin
          active   <= 1'b0;
          busy_end <= 1'b1;
        end else if ({1'b0, cnt} + 1'b1 >= {1'b0, limit_q}) begin
          active   <= 1'b0;
          dtimeout <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_wait_bounded_r9: assert property (@(posedge clk) disable iff (rst)
    active |-> ((cnt < limit_q) || (limit_q == '0)));
  p_end_needs_high_r8: assert property (@(posedge clk) disable iff (rst)
    busy_end |-> $past(dat0));
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int RESP_TIMEOUT = 64,
  parameter int DTW          = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [5:0]       cmd_index,
  input  logic [31:0]      cmd_arg,
  input  logic [1:0]       resp_kind,
  input  logic             cmd_busy_wait,
  input  logic             cmd_stop,
  input  logic [DTW-1:0]   data_timer,
  input  logic [NFLAG-1:0] flag_clear,
  input  logic [NFLAG-1:0] flag_mask,
  output logic             sd_clk,
  output logic             cmd_out,
  output logic             cmd_oe,
  input  logic             cmd_in,
  input  logic             dat0_in,
  output logic [NFLAG-1:0] status,
  output logic             irq,
  output logic [31:0]      resp_w0,
  output logic [31:0]      resp_w1,
  output logic [31:0]      resp_w2,
  output logic [31:0]      resp_w3,
  output logic             cmd_active,
  output logic             data_abort
);
  cmd_state_e state;
  resp_kind_e kind_q;
  logic       busyreq_q, stop_q;
  logic [5:0] idx_q;

  logic tick, tx_load, tx_done, tx_busy;
  logic rx_arm, rx_done, rx_timeout, rx_crc_ok;
  logic [LONG_BITS-1:0] rx_frame;
  logic bw_arm, bw_end, bw_tmo, bw_active;
  logic resp_ok_c;
  logic [NFLAG-1:0] set_vec, status_q;
  logic [TOKEN_BITS-1:0] token;

  assign tx_load   = cmd_start && (state == ST_IDLE);
  assign token     = {2'b01, cmd_index, cmd_arg,
                      crc7_40({2'b01, cmd_index, cmd_arg}), 1'b1};
  assign rx_arm    = (state == ST_TX) && tx_done && (kind_q != RK_NONE);
  assign resp_ok_c = (kind_q == RK_SHORT_NOCRC) || rx_crc_ok;
  assign bw_arm    = (state == ST_RX) && rx_done && resp_ok_c && busyreq_q && !dat0_in;

  sdcmd_clkgen #(.DIV(CLK_DIV)) clkgen_i (
    .clk(clk), .rst(rst), .tick(tick), .sd_clk(sd_clk));

  sdcmd_tx tx_i (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .token(token),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(tx_busy), .done(tx_done));

  sdcmd_rx #(.TIMEOUT(RESP_TIMEOUT)) rx_i (
    .clk(clk), .rst(rst), .tick(tick), .arm(rx_arm),
    .long_resp(kind_q == RK_LONG), .cmd_in(cmd_in), .done(rx_done),
    .timeout(rx_timeout), .crc_ok(rx_crc_ok), .frame(rx_frame));

  sdcmd_busywait #(.DTW(DTW)) bw_i (
    .clk(clk), .rst(rst), .tick(tick), .arm(bw_arm), .limit(data_timer),
    .dat0(dat0_in), .busy_end(bw_end), .dtimeout(bw_tmo), .active(bw_active));

  always_comb begin
    set_vec = '0;
    case (state)
      ST_TX: if (tx_done && kind_q == RK_NONE) set_vec[F_SENT] = 1'b1;
      ST_RX: begin
        if (rx_timeout) set_vec[F_CTMO] = 1'b1;
        else if (rx_done) begin
          if (resp_ok_c) set_vec[F_RESPOK]  = 1'b1;
          else           set_vec[F_CRCFAIL] = 1'b1;
          if (bw_arm)    set_vec[F_BUSY]    = 1'b1;
        end
      end
      ST_BUSY: begin
        if (bw_end) set_vec[F_BUSYEND] = 1'b1;
        if (bw_tmo) set_vec[F_DTMO]    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kind_q     <= RK_NONE;
      busyreq_q  <= 1'b0;
      stop_q     <= 1'b0;
      idx_q      <= '0;
      status_q   <= '0;
      irq        <= 1'b0;
      data_abort <= 1'b0;
      resp_w0    <= '0;
      resp_w1    <= '0;
      resp_w2    <= '0;
      resp_w3    <= '0;
    end else begin
      data_abort <= 1'b0;
      status_q   <= (status_q & ~flag_clear) | set_vec;
      irq        <= |(status_q & flag_mask);
      case (state)
        ST_IDLE: if (tx_load) begin
          state     <= ST_TX;
          kind_q    <= resp_kind_e'(resp_kind);
          busyreq_q <= cmd_busy_wait;
          stop_q    <= cmd_stop;
          idx_q     <= cmd_index;
        end
        ST_TX: if (tx_done) begin
          data_abort <= stop_q;
          state      <= (kind_q == RK_NONE) ? ST_IDLE : ST_RX;
        end
        ST_RX: begin
          if (rx_timeout) state <= ST_IDLE;
          else if (rx_done) begin
            if (kind_q == RK_LONG) begin
              resp_w0 <= rx_frame[127:96];
              resp_w1 <= rx_frame[95:64];
              resp_w2 <= rx_frame[63:32];
              resp_w3 <= rx_frame[31:0];
            end else begin
              resp_w0 <= rx_frame[39:8];
            end
            state <= bw_arm ? ST_BUSY : ST_IDLE;
          end
        end
        ST_BUSY: if (bw_end || bw_tmo) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign status     = status_q;
  assign cmd_active = (state != ST_IDLE);

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && state != ST_IDLE) |=> ($stable(idx_q) && $stable(kind_q)));
  p_no_wait_without_resp_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX && kind_q == RK_NONE) |=> (state != ST_RX));
  p_crc_verdict_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[F_CRCFAIL]) |-> !$rose(status_q[F_RESPOK]));
  p_busy_state_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY) |-> (bw_active || bw_end || bw_tmo));
  p_irq_has_source_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|status_q));
  p_abort_only_stop_r12: assert property (@(posedge clk) disable iff (rst)
    data_abort |-> ($past(stop_q) && !tx_busy));
endmodule

// File: tb/sdcmd_engine_tb_top.sv
`timescale 1ns/1ps
module sdcmd_engine_tb_top;
  localparam int DTW = 16;
  localparam logic [6:0] S_CRC  = 7'h01, S_TO   = 7'h02, S_OK  = 7'h04,
                         S_SENT = 7'h08, S_BUSY = 7'h10, S_BEND = 7'h20,
                         S_DTO  = 7'h40;

  logic clk = 0, rst = 1;
  logic cmd_start = 0, cmd_busy_wait = 0, cmd_stop = 0;
  logic [5:0] cmd_index = 0;
  logic [31:0] cmd_arg = 0;
  logic [1:0] resp_kind = 0;
  logic [DTW-1:0] data_timer = 16'd1000;
  logic [6:0] flag_clear = 0, flag_mask = 0;
  logic cmd_in = 1, dat0_in = 1;
  logic sd_clk, cmd_out, cmd_oe, irq, cmd_active, data_abort;
  logic [6:0] status;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

  int checks = 0, failures = 0;
  bit abort_seen = 0;

  typedef struct {
    string tag; logic [6:0] st; int nw;
    logic [31:0] w0, w1, w2, w3;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  sdcmd_engine #(.CLK_DIV(4), .RESP_TIMEOUT(64), .DTW(DTW)) dut_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .resp_kind(resp_kind), .cmd_busy_wait(cmd_busy_wait),
    .cmd_stop(cmd_stop), .data_timer(data_timer), .flag_clear(flag_clear),
    .flag_mask(flag_mask), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in), .dat0_in(dat0_in), .status(status), .irq(irq),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3),
    .cmd_active(cmd_active), .data_abort(data_abort));

  task automatic check(input string tag, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] tb_crc(input logic [119:0] d, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic m;
      m = c[6] ^ d[i];
      c = {c[5:0], m};
      c[3] = c[3] ^ m;
    end
    return c;
  endfunction

  function automatic logic [47:0] tb_token(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, tb_crc({80'b0, 2'b01, idx, arg}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] short_reply(input logic [5:0] idx, input logic [31:0] pl, input bit bad);
    logic [6:0] c = tb_crc({80'b0, 2'b00, idx, pl}, 40);
    if (bad) c = c ^ 7'h01;
    return {88'b0, 2'b00, idx, pl, c, 1'b1};
  endfunction

  function automatic logic [135:0] long_reply(input logic [119:0] body, input bit bad);
    logic [6:0] c = tb_crc(body, 120);
    if (bad) c = c ^ 7'h40;
    return {2'b00, 6'h3F, body, c, 1'b1};
  endfunction

  // Monitor: pops the expected outcome whenever a command completes
  logic act_prev = 0;
  always @(negedge clk) begin
    exp_t e;
    if (act_prev && !cmd_active) begin
      if (exp_q.size() == 0) check("R2 unexpected completion", 1, 0);
      else begin
        e = exp_q.pop_front();
        check({e.tag, " status"}, status, e.st);
        if (e.nw >= 1) check({e.tag, " word0"}, resp_w0, e.w0);
        if (e.nw == 4) begin
          check({e.tag, " word1"}, resp_w1, e.w1);
          check({e.tag, " word2"}, resp_w2, e.w2);
          check({e.tag, " word3"}, resp_w3, e.w3);
        end
      end
    end
    act_prev = cmd_active;
    if (data_abort) abort_seen = 1;
  end

  // Driver: pushes the expected outcome, plays the command and the card side
  task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                         input logic [1:0] kind, input bit bw, input bit stp,
                         input bit respond, input logic [135:0] rb, input int rlen,
                         input int gap, input int release_after,
                         input logic [6:0] est, input int nw,
                         input logic [31:0] e0, input logic [31:0] e1,
                         input logic [31:0] e2, input logic [31:0] e3);
    exp_t e;
    logic [47:0] got = '0;
    int n = 0;
    @(negedge clk) flag_clear = 7'h7F;
    @(negedge clk) flag_clear = 7'h00;
    e.tag = tag; e.st = est; e.nw = nw; e.w0 = e0; e.w1 = e1; e.w2 = e2; e.w3 = e3;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; resp_kind = kind;
    cmd_busy_wait = bw; cmd_stop = stp; cmd_start = 1;
    @(negedge clk) cmd_start = 0;
    while (n < 48) begin
      @(posedge sd_clk);
      if (cmd_oe) begin got = {got[46:0], cmd_out}; n++; end
    end
    check({tag, " R1 token"}, got, tb_token(idx, arg));
    if (respond) begin
      repeat (gap) @(posedge sd_clk);
      for (int i = rlen - 1; i >= 0; i--) begin
        @(posedge sd_clk);
        cmd_in = rb[i];
      end
      @(posedge sd_clk) cmd_in = 1;
    end
    if (release_after >= 0) begin
      repeat (release_after) @(posedge sd_clk);
      dat0_in = 1;
    end
    @(negedge clk);
    while (cmd_active) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [119:0] body;
    logic [135:0] lr;
    body = {32'h11223344, 32'h55667788, 32'h99AABBCC, 24'hDDEEFF};
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // Reset state (R10, R1, R11)
    check("R10 reset status", status, 0);
    check("R1 reset cmd_oe", cmd_oe, 0);
    check("R1 reset cmd_out", cmd_out, 1);
    check("R11 reset irq", irq, 0);
    check("R2 reset active", cmd_active, 0);

    // R1: known token for index 0, argument 0 (CRC7 = 0x4A)
    check("R1 known token", tb_token(6'd0, 32'd0), 48'h40_0000_0000_95);
    // R3: no response, sent flag
    run_cmd("R3 no-resp", 6'd0, 32'd0, 2'b00, 0, 0, 0, '0, 0, 0, -1,
            S_SENT, 0, 0, 0, 0, 0);
    check("R12 no abort for plain command", abort_seen, 0);

    // R2 + R4: second start mid-token is ignored; good short reply
    fork
      run_cmd("R2 R4 short ok", 6'd17, 32'h1234_5678, 2'b01, 0, 0, 1,
              short_reply(6'd17, 32'hCAFE_F00D, 0), 48, 2, -1,
              S_OK, 1, 32'hCAFE_F00D, 0, 0, 0);
      begin
        repeat (12) @(negedge clk);
        cmd_index = 6'd5; cmd_arg = 32'hFFFF_0000; cmd_start = 1;
        @(negedge clk) cmd_start = 0;
      end
    join

    // R4 bad CRC, with interrupt mask on the CRC-fail bit (R11)
    flag_mask = S_CRC;
    run_cmd("R4 short bad crc", 6'd13, 32'h0000_0001, 2'b01, 0, 0, 1,
            short_reply(6'd13, 32'h0BAD_0BAD, 1), 48, 2, -1,
            S_CRC, 0, 0, 0, 0, 0);
    check("R11 irq on masked flag", irq, 1);
    @(negedge clk) flag_clear = 7'h7F;
    @(negedge clk) flag_clear = 7'h00;
    repeat (2) @(negedge clk);
    check("R10 clear all", status, 0);
    check("R11 irq drops after clear", irq, 0);

    // R5: CRC ignored
    run_cmd("R5 short nocrc", 6'd41, 32'hA5A5_5A5A, 2'b10, 0, 0, 1,
            short_reply(6'd41, 32'h7654_3210, 1), 48, 2, -1,
            S_OK, 1, 32'h7654_3210, 0, 0, 0);
    check("R11 unmasked flag gives no irq", irq, 0);
    flag_mask = 0;

    // R6: long reply good and bad
    lr = long_reply(body, 0);
    run_cmd("R6 long ok", 6'd2, 32'd0, 2'b11, 0, 0, 1, lr, 136, 2, -1,
            S_OK, 4, body[119:88], body[87:56], body[55:24], lr[31:0]);
    run_cmd("R6 long bad crc", 6'd9, 32'h0001_0000, 2'b11, 0, 0, 1,
            long_reply(body, 1), 136, 2, -1, S_CRC, 0, 0, 0, 0, 0);

    // R7: missing reply, late reply
    run_cmd("R7 no reply", 6'd8, 32'h1AA, 2'b01, 0, 0, 0, '0, 0, 0, -1,
            S_TO, 0, 0, 0, 0, 0);
    run_cmd("R7 late reply", 6'd8, 32'h1AA, 2'b01, 0, 0, 1,
            short_reply(6'd8, 32'h0000_01AA, 0), 48, 55, -1,
            S_OK, 1, 32'h0000_01AA, 0, 0, 0);

    // R8: busy then release; busy requested but line high
    data_timer = 16'd1000;
    dat0_in = 0;
    run_cmd("R8 busy release", 6'd7, 32'h0002_0000, 2'b01, 1, 0, 1,
            short_reply(6'd7, 32'h0000_0900, 0), 48, 2, 20,
            S_OK | S_BUSY | S_BEND, 1, 32'h0000_0900, 0, 0, 0);
    @(negedge clk) flag_clear = S_BUSY;
    @(negedge clk) flag_clear = 0;
    @(negedge clk);
    check("R10 selective clear", status, S_OK | S_BEND);
    run_cmd("R8 busy line high", 6'd7, 32'h0002_0000, 2'b01, 1, 0, 1,
            short_reply(6'd7, 32'h0000_0900, 0), 48, 2, -1,
            S_OK, 1, 32'h0000_0900, 0, 0, 0);

    // R9: busy outlives the limit
    data_timer = 16'd10;
    dat0_in = 0;
    run_cmd("R9 data timeout", 6'd6, 32'h03B7_0100, 2'b01, 1, 0, 1,
            short_reply(6'd6, 32'h0000_0800, 0), 48, 2, -1,
            S_OK | S_BUSY | S_DTO, 1, 32'h0000_0800, 0, 0, 0);
    dat0_in = 1;

    // R12: stop command pulses abort
    abort_seen = 0;
    run_cmd("R12 stop", 6'd12, 32'd0, 2'b00, 0, 1, 0, '0, 0, 0, -1,
            S_SENT, 0, 0, 0, 0, 0);
    check("R12 abort pulse seen", abort_seen, 1);
    check("R12 abort idle", data_abort, 0);
    check("R2 all outcomes seen", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule